// File: doc/BRIEF.md
# BCD to Seven-Segment Decoder with Blanking Control

This block is a purely combinational decoder. It turns a 4-bit code into seven active-high segment drives for a single display digit. Codes 0 to 9 show decimal digits. Codes 10 to 15 show fixed non-numeric symbols, and code 15 shows a dark digit.

Three active-low control inputs sit on top of the decoding:
- A forced-blank input darkens the digit unconditionally.
- A lamp-test input lights every segment.
- A ripple-blank input darkens the digit only when its code is zero.

Whenever the digit is suppressed as a zero, the decoder pulls its ripple-blank output low. When the digits of a multi-digit display are chained from the most significant position downward, each ripple-blank output feeds the next digit's ripple-blank input. Leading zeros are then suppressed across the whole display.

On real parts, the forced-blank input and the ripple-blank output share one open-collector pin. Here that pin is split into a separate input and a separate output. A third output reports the level of the shared wired-AND node.

Top module: `bcd_seg_decoder`

## Requirements
- R1: With forced-blank, ripple-blank and lamp-test inputs all high, codes 0 to 9 drive `segs` (bit 0 = a, bit 1 = b, … bit 6 = g) to 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F respectively.
- R2: Under the same control conditions, codes 10 to 15 drive `segs` to 0x58, 0x4C, 0x62, 0x69, 0x78 and 0x00 respectively.
- R3: A low on `blank_n` drives `segs` to 0x00, whatever the code, `rbi_n` and `lamp_n`.
- R4: A low on `lamp_n` while `blank_n` is high drives `segs` to 0x7F for every code and either level of `rbi_n`. Lamp test therefore outranks zero blanking.
- R5: When `rbi_n` is low, the code is 0 and `lamp_n` is high, the decoder drives `segs` to 0x00 and `rbo_n` low.
- R6: `rbo_n` is high in every input combination other than the one named in R5.
- R7: A low on `rbi_n` with a nonzero code, and `blank_n` and `lamp_n` both high, leaves `segs` at the normal R1/R2 pattern.
- R8: `node_level` equals `blank_n` AND `rbo_n`. Whenever `node_level` is low, `segs` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code | input | 4 | Code to display, 0 to 15 |
| blank_n | input | 1 | Forced blank, active low, highest priority |
| rbi_n | input | 1 | Ripple-blank input, active low, blanks a zero code |
| lamp_n | input | 1 | Lamp test, active low, lights every segment |
| segs | output | 7 | Segment drives {g,f,e,d,c,b,a}, active high |
| rbo_n | output | 1 | Ripple-blank output, low only while a zero is suppressed |
| node_level | output | 1 | Level of the shared wired-AND blanking node |

## Verification
The bench builds the decoder with its default parameters: a 4-bit code and seven segments. With 16 codes and three control bits, the input space has only 128 points. A directed sweep therefore covers every code under every control combination, including the zero-code and lamp-test overlaps where the priority order matters. Seeded random vectors then revisit the same space in a shuffled order, so that any dependence on the sequence of inputs would show up.

// File: rtl/sevseg_pkg.sv
// Package: sevseg_pkg
// Shared widths and constants for the seven-segment decoder.
// Assumes segment bit 0 is segment a and bit 6 is segment g.
package sevseg_pkg;
    localparam int unsigned CODE_W  = 4;
    localparam int unsigned SEG_W   = 7;
    localparam int unsigned N_CODES = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_W-1:0]  seg_t;

    localparam seg_t SEG_DARK = '0;
    localparam seg_t SEG_LIT  = '1;
endpackage

// File: rtl/seg_font.sv
// Module: seg_font
// Maps a code to its raw segment pattern, with no control inputs applied.
// Assumes a 4-bit code. Codes above 9 give fixed symbols, and 15 gives a dark digit.
module seg_font
    import sevseg_pkg::*;
(
    input  code_t code,
    output seg_t  pattern
);
    // Look up the glyph for each code.
    always_comb begin
        unique case (code)
            4'd0:    pattern = 7'h3F;
            4'd1:    pattern = 7'h06;
            4'd2:    pattern = 7'h5B;
            4'd3:    pattern = 7'h4F;
            4'd4:    pattern = 7'h66;
            4'd5:    pattern = 7'h6D;
            4'd6:    pattern = 7'h7D;
            4'd7:    pattern = 7'h07;
            4'd8:    pattern = 7'h7F;
            4'd9:    pattern = 7'h6F;
            4'd10:   pattern = 7'h58;
            4'd11:   pattern = 7'h4C;
            4'd12:   pattern = 7'h62;
            4'd13:   pattern = 7'h69;
            4'd14:   pattern = 7'h78;
            default: pattern = SEG_DARK;
        endcase
    end
endmodule

// File: rtl/zero_detect.sv
// Module: zero_detect
// Flags an all-zero code for the ripple-blank logic.
// Assumes a code width taken from the package.
module zero_detect
    import sevseg_pkg::*;
(
    input  code_t code,
    output logic  is_zero
);
    // Reduce the code to a single zero flag.
    always_comb is_zero = ~|code;
endmodule

// File: rtl/blank_ctrl.sv
// Module: blank_ctrl
// Applies the control priority: forced blank first, then lamp test, then zero ripple blank.
// Assumes active-low controls and a raw pattern from seg_font.
module blank_ctrl
    import sevseg_pkg::*;
(
    input  seg_t pattern,
    input  logic is_zero,
    input  logic blank_n,
    input  logic rbi_n,
    input  logic lamp_n,
    output seg_t segs,
    output logic rbo_n
);
    logic zero_sup;

    // Zero suppression holds only for a zero code with ripple blank active and no lamp test.
    always_comb zero_sup = is_zero & ~rbi_n & lamp_n;

    // Choose the segment drive in priority order.
    always_comb begin
        if (!blank_n)     segs = SEG_DARK;
        else if (!lamp_n) segs = SEG_LIT;
        else if (zero_sup) segs = SEG_DARK;
        else              segs = pattern;
    end

    // Pull the ripple-blank output low only while a zero is being suppressed.
    always_comb rbo_n = ~zero_sup;
endmodule

// File: rtl/bcd_seg_decoder.sv
// Module: bcd_seg_decoder
// Top level of the seven-segment decoder with blanking and lamp test.
// Assumes the shared blanking pin is split into blank_n (input) and rbo_n (output);
// node_level reports the wired-AND of the two.
module bcd_seg_decoder
    import sevseg_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              blank_n,
    input  logic              rbi_n,
    input  logic              lamp_n,
    output logic [SEG_W-1:0]  segs,
    output logic              rbo_n,
    output logic              node_level
);
    seg_t raw_pat;
    logic zero_flag;

    seg_font u_font (
        .code    (code),
        .pattern (raw_pat)
    );

    zero_detect u_zero (
        .code    (code),
        .is_zero (zero_flag)
    );

    blank_ctrl u_ctrl (
        .pattern (raw_pat),
        .is_zero (zero_flag),
        .blank_n (blank_n),
        .rbi_n   (rbi_n),
        .lamp_n  (lamp_n),
        .segs    (segs),
        .rbo_n   (rbo_n)
    );

    // Model the shared open-collector node as a wired-AND.
    always_comb node_level = blank_n & rbo_n;
endmodule

// File: rtl/bcd_seg_decoder_chk.sv
// Module: bcd_seg_decoder_chk
// Checks the blanking properties of the decoder through immediate assertions.
// Assumes purely combinational behaviour and skips any check while an input is unknown.
module bcd_seg_decoder_chk
    import sevseg_pkg::*;
(
    input logic [CODE_W-1:0] code,
    input logic              blank_n,
    input logic              rbi_n,
    input logic              lamp_n,
    input logic [SEG_W-1:0]  segs,
    input logic              rbo_n,
    input logic              node_level
);
    // Evaluate the properties whenever any port changes.
    always_comb begin
        if (!$isunknown({code, blank_n, rbi_n, lamp_n, segs, rbo_n, node_level})) begin
            p_force_dark_r3: assert (blank_n || segs == '0)
                else $error("forced blank left segments lit");
            p_lamp_all_r4: assert (!blank_n || lamp_n || segs == '1)
                else $error("lamp test did not light all segments");
            p_zero_dark_r5: assert (rbo_n || segs == '0)
                else $error("ripple output low while digit lit");
            p_rbo_cause_r6: assert (rbo_n || (code == '0 && !rbi_n && lamp_n))
                else $error("ripple output low without zero suppression");
            p_node_dark_r8: assert (node_level || segs == '0)
                else $error("low blanking node left segments lit");
        end
    end
endmodule

bind bcd_seg_decoder bcd_seg_decoder_chk u_chk (
    .code       (code),
    .blank_n    (blank_n),
    .rbi_n      (rbi_n),
    .lamp_n     (lamp_n),
    .segs       (segs),
    .rbo_n      (rbo_n),
    .node_level (node_level)
);

// File: tb/bcd_seg_decoder_tb.sv
// Bench for bcd_seg_decoder: a directed sweep of all inputs, then seeded random vectors.
module bcd_seg_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code = '0;
    logic       blank_n = 1'b0, rbi_n = 1'b1, lamp_n = 1'b1;
    logic [6:0] segs;
    logic       rbo_n, node_level;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    bcd_seg_decoder dut_i (
        .code(code), .blank_n(blank_n), .rbi_n(rbi_n), .lamp_n(lamp_n),
        .segs(segs), .rbo_n(rbo_n), .node_level(node_level)
    );

    // Glyph table taken from R1 and R2.
    function automatic logic [6:0] glyph(input logic [3:0] c);
        case (c)
            4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
            4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
            4'd9: return 7'h6F;  4'd10: return 7'h58; 4'd11: return 7'h4C;
            4'd12: return 7'h62; 4'd13: return 7'h69; 4'd14: return 7'h78;
            default: return 7'h00;
        endcase
    endfunction

    // Zero-suppression condition of R5.
    function automatic bit zsup(input logic [3:0] c, input bit r, input bit l);
        return (c == 4'd0) && !r && l;
    endfunction

    // Expected segments from R3, R4, R5, R1/R2 and R7, in that priority order.
    function automatic logic [6:0] exp_segs(input logic [3:0] c, input bit b, input bit r, input bit l);
        if (!b) return 7'h00;
        if (!l) return 7'h7F;
        if (zsup(c, r, l)) return 7'h00;
        return glyph(c);
    endfunction

    // Count one check and report it on mismatch.
    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s code=%0d bl=%b rbi=%b lt=%b actual=%h expected=%h",
                     req, code, blank_n, rbi_n, lamp_n, act, exp);
        end
    endtask

    // Drive one vector at a falling edge, then check all outputs 1 ns later.
    task automatic apply(input logic [3:0] c, input bit b, input bit r, input bit l);
        string tag;
        @(negedge clk);
        code = c; blank_n = b; rbi_n = r; lamp_n = l;
        #1;
        if (!b)                 tag = "R3";
        else if (!l)            tag = "R4";
        else if (zsup(c, r, l)) tag = "R5";
        else if (!r)            tag = "R7";
        else if (c > 4'd9)      tag = "R2";
        else                    tag = "R1";
        check(tag, {1'b0, segs}, {1'b0, exp_segs(c, b, r, l)});
        check(zsup(c, r, l) ? "R5" : "R6", {7'd0, rbo_n}, {7'd0, !zsup(c, r, l)});
        check("R8", {7'd0, node_level}, {7'd0, b && !zsup(c, r, l)});
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset phase: the stimulus holds forced blank, so the digit must stay dark (R3).
        repeat (3) @(negedge clk);
        #1;
        check("R3", {1'b0, segs}, 8'h00);
        rst_n = 1'b1;

        // Directed: the plain glyphs R1, R2.
        for (int c = 0; c < 16; c++) apply(c[3:0], 1'b1, 1'b1, 1'b1);
        // Directed corners: zero blank R5, lamp over zero blank R4, blank over lamp R3.
        apply(4'd0, 1'b1, 1'b0, 1'b1);
        apply(4'd0, 1'b1, 1'b0, 1'b0);
        apply(4'd8, 1'b0, 1'b0, 1'b0);
        apply(4'd5, 1'b1, 1'b0, 1'b1);   // R7
        // Exhaustive sweep of every code against every control combination.
        for (int v = 0; v < 128; v++) apply(v[3:0], v[4], v[5], v[6]);
        // Seeded random vectors.
        begin
            int unsigned seed_v;
            seed_v = $urandom(32'h5EC7);
            for (int i = 0; i < 400; i++) begin
                logic [6:0] r;
                r = 7'($urandom);
                apply(r[3:0], r[4], r[5], r[6]);
            end
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule